// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

This block holds two down-counting interval timers and a free-running programmable prescaler behind a small register port. Each timer has an 8-bit divide value, a run or hold-and-load mode, a write-only interrupt acknowledge and a clock source choice. Timer 0 counts either fixed-rate enable strobes or prescaler wraps. Timer 1 counts either its own fixed-rate strobes or underflows of timer 0, which chains the two into one longer interval.

When a timer in run mode underflows, it reloads its divide value and raises a level interrupt. The interrupt stays high until software acknowledges it. Software can read both live counts, so the time elapsed in the current period is the divide value minus the count. It can also read the current prescaler count. All fixed-rate sources arrive as single-cycle enables on the block clock. Given a 25 kHz strobe and a divide value of 250, timer 0 interrupts at 100 Hz.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register reads zero, except the count word at address 2, which reads 0x01000100 because both counts hold 256. Both interrupt outputs are low and both timers are held.
- R2: In hold-and-load mode (run bit 0), a timer's count is reloaded every cycle with its effective divide value, and its ticks have no effect. A divide field of 0 means 256.
- R3: In run mode a timer's count drops by one for each tick of its selected source and holds in cycles without a tick.
- R4: A tick that arrives while the count is 1 reloads the effective divide value on the same clock edge and sets that timer's interrupt. The interrupt period is therefore the divide value in ticks, so a divide value of 250 gives one interrupt per 250 ticks.
- R5: Writing the control word with a timer's acknowledge bit at 1 clears that timer's interrupt, and writing the bit as 0 leaves it unchanged. An underflow on the same edge as an acknowledge wins, so the interrupt stays set.
- R6: When timer 1's source bit is 1, timer 1 counts once per timer 0 underflow and ignores its fixed-rate strobe. When the bit is 0, it counts its fixed-rate strobe.
- R7: When timer 0's source bit is 1, timer 0 counts prescaler wraps. The prescaler counts down one per clock and wraps, reloading its reload value, in a cycle where its count is 0 or 1. Writing the reload register loads the count on that edge, so after a write of N (N ≥ 1) the first wrap falls N cycles later, and every N cycles after that.
- R8: The register map is as follows. Address 0 is the control word; its readback shows the acknowledge bits as 0. Address 1 is the prescaler reload value. Address 2 holds the counts, timer 0 in bits 8:0 and timer 1 in bits 24:16. Address 3 is the current prescaler count. In the control word, timer 0 uses bits 10:0 and timer 1 uses bits 26:16, each laid out as {source, acknowledge, run, divide[7:0]}. Read data is registered and shows the state as it stood in the cycle the address was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 32 | Registered read data |
| tick0_fixed | input | 1 | Fixed-rate enable strobe for timer 0 |
| tick1_fixed | input | 1 | Fixed-rate enable strobe for timer 1 |
| irq0 | output | 1 | Timer 0 level interrupt |
| irq1 | output | 1 | Timer 1 level interrupt |

## Verification
A tick presented in one cycle changes the count and the interrupt on the next clock edge, and interrupts are register outputs. The bench therefore drives each stimulus for exactly one cycle from a falling edge and samples at the following falling edge. Reads take one cycle and show the state from the cycle the address was presented, so each read follows the stimulus it observes. A control write that returns a timer to run mode only takes effect one edge later, and each scenario starts from a hold, then load, then run sequence so that its count is known. In the prescaler case the interrupt is expected exactly twelve edges after the reload write (three wraps of four cycles), and it is sampled one cycle before and at that edge.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int DIV_W = 8;
  localparam int CNT_W = DIV_W + 1;
  localparam int REG_W = 32;
  localparam int CFG_W = DIV_W + 3;

  // Per-timer slice of the control word, MSB first.
  typedef struct packed {
    logic             src;
    logic             ack;
    logic             run;
    logic [DIV_W-1:0] div;
  } tmr_cfg_t;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_RELD  = 2'd1;
  localparam logic [1:0] ADDR_COUNT = 2'd2;
  localparam logic [1:0] ADDR_PSTAT = 2'd3;

  localparam int T0_LSB = 0;
  localparam int T1_LSB = 16;
endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  output logic          wrap,
  output logic [PW-1:0] count,
  output logic [PW-1:0] reload
);
  assign wrap = (count <= PW'(1)) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      reload <= '0;
    end else if (load) begin
      count  <= load_val;
      reload <= load_val;
    end else if (wrap) begin
      count <= reload;
    end else begin
      count <= count - PW'(1);
    end
  end

  // R7: a wrap restarts the count at the stored reload value
  assert_wrap_reload_R7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> count == $past(reload));

  // R7: a reload write loads the count on that edge
  assert_load_count_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val));
endmodule

// File: rtl/dit_timer.sv
module dit_timer
  import dit_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          src_alt,
  input  logic [DW-1:0] div,
  input  logic          tick_fixed,
  input  logic          tick_alt,
  input  logic          ack,
  output logic [DW:0]   cnt,
  output logic          uf,
  output logic          flag
);
  localparam int CW = DW + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << DW;

  logic [CW-1:0] eff;
  logic          step;

  assign eff  = (div == '0) ? FULL : {1'b0, div};
  assign step = src_alt ? tick_alt : tick_fixed;
  assign uf   = run && step && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)            cnt <= FULL;
    else if (!run)      cnt <= eff;
    else if (uf)        cnt <= eff;
    else if (step)      cnt <= cnt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (uf)   flag <= 1'b1;
    else if (ack)  flag <= 1'b0;
  end

  // R2: count always stays within 1..256
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) && (cnt <= FULL));

  // R2: hold-and-load mode loads the effective divide value
  assert_hold_load_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == $past(eff));

  // R4: underflow reloads and raises the flag
  assert_uf_reload_R4: assert property (@(posedge clk) disable iff (rst)
    uf |=> (cnt == $past(eff)) && flag);

  // R5: acknowledge without underflow drops the flag
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (ack && !uf) |=> !flag);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int PRE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [1:0]        rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              tick0_fixed,
  input  logic              tick1_fixed,
  output logic              irq0,
  output logic              irq1
);
  localparam int GAP0 = T1_LSB - CFG_W;
  localparam int GAP1 = REG_W - T1_LSB - CFG_W;
  localparam int CGAP = T1_LSB - CNT_W;
  localparam int CTOP = REG_W - T1_LSB - CNT_W;

  tmr_cfg_t cfg_q [2];
  tmr_cfg_t cfg_w [2];
  logic [1:0] ack_req;
  logic [1:0] uf;
  logic [1:0] flag;
  logic [1:0] tick_fixed;
  logic [1:0] tick_alt;
  logic [CNT_W-1:0] cnt [2];

  logic             ctrl_wr;
  logic             pre_wrap;
  logic [PRE_W-1:0] pre_count;
  logic [PRE_W-1:0] pre_reload;
  logic             unused_wr;

  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign cfg_w[0]  = tmr_cfg_t'(wr_data[T0_LSB +: CFG_W]);
  assign cfg_w[1]  = tmr_cfg_t'(wr_data[T1_LSB +: CFG_W]);
  assign unused_wr = ^wr_data;

  assign tick_fixed = {tick1_fixed, tick0_fixed};
  assign tick_alt   = {uf[0], pre_wrap};

  dit_prescaler #(.PW(PRE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_en && (wr_addr == ADDR_RELD)),
    .load_val (wr_data[PRE_W-1:0]),
    .wrap     (pre_wrap),
    .count    (pre_count),
    .reload   (pre_reload)
  );

  for (genvar t = 0; t < 2; t++) begin : g_tmr
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[t] <= '0;
      end else if (ctrl_wr) begin
        cfg_q[t]     <= cfg_w[t];
        cfg_q[t].ack <= 1'b0;
      end
    end

    assign ack_req[t] = ctrl_wr && cfg_w[t].ack;

    dit_timer #(.DW(DIV_W)) u_tmr (
      .clk        (clk),
      .rst        (rst),
      .run        (cfg_q[t].run),
      .src_alt    (cfg_q[t].src),
      .div        (cfg_q[t].div),
      .tick_fixed (tick_fixed[t]),
      .tick_alt   (tick_alt[t]),
      .ack        (ack_req[t]),
      .cnt        (cnt[t]),
      .uf         (uf[t]),
      .flag       (flag[t])
    );
  end

  assign irq0 = flag[0];
  assign irq1 = flag[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        ADDR_CTRL:  rd_data <= {{GAP1{1'b0}}, cfg_q[1], {GAP0{1'b0}}, cfg_q[0]};
        ADDR_RELD:  rd_data <= REG_W'(pre_reload);
        ADDR_COUNT: rd_data <= {{CTOP{1'b0}}, cnt[1], {CGAP{1'b0}}, cnt[0]};
        default:    rd_data <= REG_W'(pre_count);
      endcase
    end
  end

  // R6: in cascade mode timer 1 steps once per timer 0 underflow
  assert_cascade_step_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[1].run && cfg_q[1].src && uf[0] && (cnt[1] != CNT_W'(1)))
      |=> cnt[1] == $past(cnt[1]) - CNT_W'(1));

  // R6: in cascade mode the fixed strobe alone leaves timer 1 alone
  assert_cascade_ignore_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[1].run && cfg_q[1].src && !uf[0]) |=> $stable(cnt[1]));

  // R8: count word reflects the counts of the presenting cycle
  assert_read_count_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_COUNT) |=> rd_data[CNT_W-1:0] == $past(cnt[0]));

  // R1: nothing is pending in the first cycle after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    $fell(rst) |-> !irq0 && !irq1);
endmodule

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tick0_fixed = 1'b0;
  logic        tick1_fixed = 1'b0;
  logic        irq0, irq1;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick0_fixed(tick0_fixed),
    .tick1_fixed(tick1_fixed), .irq0(irq0), .irq1(irq1)
  );

  function automatic logic [10:0] cfg(input int dv, input bit run, input bit ack, input bit src);
    return {src, ack, run, 8'(dv)};
  endfunction

  function automatic logic [31:0] ctrl(input logic [10:0] c0, input logic [10:0] c1);
    return {5'b0, c1, 5'b0, c0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Every task starts and ends on a falling edge and spans whole cycles.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic tick0();
    tick0_fixed = 1'b1;
    @(negedge clk);
    tick0_fixed = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Hold with both flags cleared, allow one load edge, then apply run bits.
  task automatic setup(input logic [10:0] c0, input logic [10:0] c1);
    logic [10:0] h0, h1;
    h0 = c0; h0[8] = 1'b0; h0[9] = 1'b1;
    h1 = c1; h1[8] = 1'b0; h1[9] = 1'b1;
    wr(2'd0, ctrl(h0, h1));
    idle(1);
    wr(2'd0, ctrl(c0, c1));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq0", 32'(irq0), 0);
    check("R1 irq1", 32'(irq1), 0);
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 reload", d, 0);
    rd(2'd2, d); check("R1 counts", d, 32'h0100_0100);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    setup(cfg(5, 0, 0, 0), cfg(0, 0, 0, 0));
    tick0();
    rd(2'd2, d); check("R2 hold count", d, 32'h0100_0005);
    rd(2'd0, d); check("R8 ctrl readback", d, ctrl(cfg(5, 0, 0, 0), cfg(0, 0, 0, 0)));
    setup(cfg(0, 1, 0, 0), cfg(0, 0, 0, 0));
    tick0();
    rd(2'd2, d); check("R2 divide zero is 256", d[8:0], 255);
  endtask

  task automatic t_run();
    logic [31:0] d;
    setup(cfg(5, 1, 0, 0), cfg(0, 0, 0, 0));
    for (int i = 4; i >= 1; i--) begin
      tick0();
      rd(2'd2, d); check("R3 step", d[8:0], 32'(i));
    end
    idle(3);
    rd(2'd2, d); check("R3 hold without tick", d[8:0], 1);
    check("R4 no irq before underflow", 32'(irq0), 0);
    tick0();
    check("R4 irq on underflow", 32'(irq0), 1);
    rd(2'd2, d); check("R4 reload", d[8:0], 5);
    wr(2'd0, ctrl(cfg(5, 1, 0, 0), cfg(0, 0, 0, 0)));
    check("R5 no-op keeps irq", 32'(irq0), 1);
    wr(2'd0, ctrl(cfg(5, 1, 1, 0), cfg(0, 0, 0, 0)));
    check("R5 ack clears irq", 32'(irq0), 0);
    rd(2'd2, d); check("R5 ack keeps count", d[8:0], 5);
  endtask

  task automatic t_collide();
    setup(cfg(2, 1, 0, 0), cfg(0, 0, 0, 0));
    tick0();
    tick0_fixed = 1'b1;
    wr(2'd0, ctrl(cfg(2, 1, 1, 0), cfg(0, 0, 0, 0)));
    tick0_fixed = 1'b0;
    check("R5 underflow beats ack", 32'(irq0), 1);
  endtask

  task automatic t_rate();
    logic [31:0] d;
    setup(cfg(250, 1, 0, 0), cfg(0, 0, 0, 0));
    repeat (249) tick0();
    check("R4 no irq at 249 ticks", 32'(irq0), 0);
    rd(2'd2, d); check("R4 count at 249 ticks", d[8:0], 1);
    tick0();
    check("R4 irq at 250 ticks", 32'(irq0), 1);
  endtask

  task automatic t_cascade();
    logic [31:0] d;
    setup(cfg(2, 1, 0, 0), cfg(3, 1, 0, 1));
    tick1_fixed = 1'b1; idle(1); tick1_fixed = 1'b0;
    rd(2'd2, d); check("R6 fixed strobe ignored", d, 32'h0003_0002);
    tick0(); tick0();
    rd(2'd2, d); check("R6 one cascade step", d, 32'h0002_0002);
    check("R6 irq1 low", 32'(irq1), 0);
    repeat (4) tick0();
    rd(2'd2, d); check("R6 cascade wrap", d, 32'h0003_0002);
    check("R6 irq1 set", 32'(irq1), 1);
    setup(cfg(2, 0, 0, 0), cfg(3, 1, 0, 0));
    tick1_fixed = 1'b1; idle(1); tick1_fixed = 1'b0;
    rd(2'd2, d); check("R6 fixed source steps", d[24:16], 2);
  endtask

  task automatic t_presc();
    logic [31:0] d;
    wr(2'd1, 32'd1000);
    setup(cfg(3, 1, 0, 1), cfg(0, 0, 0, 0));
    wr(2'd1, 32'd4);
    rd(2'd3, d); check("R8 prescaler status", d, 4);
    rd(2'd3, d); check("R7 prescaler counts down", d, 3);
    rd(2'd1, d); check("R8 reload readback", d, 4);
    idle(8);
    check("R7 no irq before third wrap", 32'(irq0), 0);
    idle(1);
    check("R7 irq on third wrap", 32'(irq0), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    t_reset();
    t_hold();
    t_run();
    t_collide();
    t_rate();
    t_cascade();
    t_presc();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule